// File: doc/BRIEF.md
# Gated Pixel-Clock Video Output Port

This block drains a stream of 16-bit pixel words from an upstream valid/ready source and drives them to an external video sink. Alongside the data it drives a generated pixel clock, an active-low horizontal sync, an active-high vertical sync and a data-valid qualifier. The pixel clock is produced from registers, not by gating the system clock. It leaves its idle level only while data is valid, and a configuration bit selects its polarity. Sync, data and data-valid always change at the inactive edge, so they are settled at the active edge where the sink samples them.

The system clock `clk` runs at twice the rate of the video source clock, so one `clk` cycle is half a source period. Three modes are available. In 16-bit mode with divide-by-1, the pixel clock runs at the source rate. In 16-bit mode with divide-by-2, it runs at half the source rate. In 8-bit mode it always runs at half the source rate, and each input word is sent as two bytes on the low lane, low byte first. The upstream stream marks the first word of every line and the first word of every frame. The port consumes one word per word-time of the selected mode. When no word is waiting at that point, it stops the pixel clock cleanly at its idle level.

Configuration inputs are expected to be static while a stream is running. The mode is captured with each consumed word.

Top module: `zvo_port`

## Requirements
- R1: After synchronous reset is released, `vid_de` is 0, `vid_hsync_n` is 1, `vid_vsync` is 0, `in_ready` is 0 while `in_valid` is 0, and `vid_clk` is at its idle level: 1 when `cfg_invert`=0 and 0 when `cfg_invert`=1.
- R2: `in_ready` is 1 only in a cycle where `in_valid` is 1 and the port is free, meaning it is idle or in the last cycle of the current word. The word is consumed at the following clock edge.
- R3: With words offered back to back, consumption repeats every 2 cycles (16-bit, divide-by-1), every 4 cycles (16-bit, divide-by-2) or every 8 cycles (8-bit mode).
- R4: On the edge that consumes a word, several outputs change together. `vid_de` becomes 1 and `vid_clk` moves to its inactive level (equal to `cfg_invert`). The first data lane is presented, and both syncs take their new values.
- R5: Every presented pixel lane is followed by exactly one active edge of `vid_clk`, half a pixel period later: 1 cycle for 16-bit divide-by-1, 2 cycles otherwise. Data, syncs and `vid_de` hold across that edge.
- R6: In 8-bit mode, each word yields two pixel periods, carrying bits 7:0 and then bits 15:8 on `vid_data[7:0]`, with `vid_data[15:8]` at 0. In this mode `cfg_div1` has no effect on timing.
- R7: In 16-bit mode, `vid_data[15:0]` carries the whole consumed word for one pixel period.
- R8: `vid_hsync_n` is 0 for every pixel period of a word flagged start-of-line and 1 otherwise, including while idle.
- R9: `vid_vsync` becomes 1 with a start-of-frame word. It returns to 0 with the next start-of-line word that is not start-of-frame, and otherwise holds its value, including across idle gaps.
- R10: If no word is offered when the current word ends, `vid_de` falls at that edge. `vid_clk` then stays at its idle level with no edge, and `vid_hsync_n` returns to 1.
- R11: `cfg_invert`=1 inverts `vid_clk`, so the active edge becomes falling. `cfg_invert`=0 gives a clock that idles high and samples on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the video source rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 selects 16-bit output, 0 selects 8-bit |
| cfg_div1 | input | 1 | 1 selects divide-by-1 (16-bit mode only) |
| cfg_invert | input | 1 | 1 inverts the pixel clock polarity |
| in_valid | input | 1 | Upstream word available |
| in_ready | output | 1 | Word consumed at the next edge |
| in_data | input | 16 | Upstream pixel word |
| in_sol | input | 1 | Word is first of a line |
| in_sof | input | 1 | Word is first of a frame |
| vid_clk | output | 1 | Gated pixel clock |
| vid_data | output | 16 | Pixel data lanes |
| vid_hsync_n | output | 1 | Horizontal sync, active low |
| vid_vsync | output | 1 | Vertical sync, active high |
| vid_de | output | 1 | Data-valid qualifier |

## Verification
`in_ready` is combinational, so it is read a quarter period after the falling edge and before the edge that consumes the word. The consumed word must show up at the very next falling-edge sample, with `vid_de` set and the clock at its inactive level. Each active pixel-clock edge is expected 1 or 2 cycles later, depending on mode. A monitor therefore compares every active transition, seen at falling-edge samples, against a queue of lanes computed from the words sent. Spacing between consumptions is counted in whole cycles against 2, 4 or 8. Idle checks are made only after a gap longer than one word-time, once the last word has certainly finished.

// File: rtl/zvo_pkg.sv
package zvo_pkg;

    localparam int unsigned MAX_WORD_CYC = 8;
    localparam int unsigned CNT_W        = $clog2(MAX_WORD_CYC);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic wide;
        logic div1;
    } mode_t;

    typedef struct packed {
        logic sol;
        logic sof;
    } mark_t;

    // divide-by-1 is honoured only for 16-bit output
    function automatic logic fast_mode(input mode_t m);
        return m.wide && m.div1;
    endfunction

    // cycles in half a pixel period
    function automatic cnt_t half_cyc(input mode_t m);
        return fast_mode(m) ? cnt_t'(1) : cnt_t'(2);
    endfunction

    // cycles in one pixel period
    function automatic cnt_t per_cyc(input mode_t m);
        return fast_mode(m) ? cnt_t'(2) : cnt_t'(4);
    endfunction

    // index of the final cycle spent on one input word
    function automatic cnt_t last_cyc(input mode_t m);
        if (!m.wide)
            return cnt_t'(7);
        return fast_mode(m) ? cnt_t'(1) : cnt_t'(3);
    endfunction

endpackage

// File: rtl/zvo_pacer.sv
module zvo_pacer
    import zvo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  mode_t cfg_mode,
    output logic  take,
    output logic  drop,
    output logic  advance,
    output cnt_t  cnt_nxt,
    output mode_t mode_q
);

    logic run_q;
    cnt_t cnt_q;
    logic last;
    logic slot;

    assign last    = run_q && (cnt_q == last_cyc(mode_q));
    assign slot    = !run_q || last;
    assign take    = slot && in_valid;
    assign drop    = last && !in_valid;
    assign advance = run_q && !last;
    assign cnt_nxt = cnt_q + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            mode_q <= '0;
        end else if (take) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            mode_q <= cfg_mode;
        end else if (drop) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (advance) begin
            cnt_q  <= cnt_nxt;
        end
    end

endmodule

// File: rtl/zvo_pclk_gen.sv
module zvo_pclk_gen (
    input  logic clk,
    input  logic rst,
    input  logic inv,
    input  logic start,
    input  logic rise,
    input  logic fall2,
    output logic pclk
);

    // lvl_q is the non-inverted level: 1 is idle, and 0 to 1 is the sampling edge
    logic lvl_q;
    logic lvl_d;

    always_comb begin
        lvl_d = lvl_q;
        if (start || fall2)
            lvl_d = 1'b0;
        else if (rise)
            lvl_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b1;
            pclk  <= !inv;
        end else begin
            lvl_q <= lvl_d;
            pclk  <= lvl_d ^ inv;
        end
    end

endmodule

// File: rtl/zvo_sync_track.sv
module zvo_sync_track
    import zvo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  mark_t mark,
    input  logic  drop,
    output logic  hsync_n,
    output logic  vsync
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync   <= 1'b0;
        end else if (take) begin
            hsync_n <= !mark.sol;
            if (mark.sof)
                vsync <= 1'b1;
            else if (mark.sol)
                vsync <= 1'b0;
        end else if (drop) begin
            hsync_n <= 1'b1;
        end
    end

endmodule

// File: rtl/zvo_lane_sel.sv
module zvo_lane_sel #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    input  logic              wide,
    input  logic              hi,
    output logic [DATA_W-1:0] lane
);

    localparam int unsigned LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] lo_part;
    logic [LANE_W-1:0] hi_part;

    assign lo_part = word[LANE_W-1:0];
    assign hi_part = word[DATA_W-1:LANE_W];

    generate
        if (DATA_W % 2 == 0) begin : g_even
            always_comb begin
                if (wide)
                    lane = word;
                else
                    lane = {{LANE_W{1'b0}}, (hi ? hi_part : lo_part)};
            end
        end else begin : g_odd
            always_comb begin
                lane = wide ? word : {{(DATA_W-LANE_W){1'b0}}, lo_part};
            end
        end
    endgenerate

endmodule

// File: rtl/zvo_port.sv
module zvo_port
    import zvo_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              cfg_div1,
    input  logic              cfg_invert,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sol,
    input  logic              in_sof,
    output logic              vid_clk,
    output logic [DATA_W-1:0] vid_data,
    output logic              vid_hsync_n,
    output logic              vid_vsync,
    output logic              vid_de
);

    mode_t cfg_mode;
    mode_t mode_q;
    mark_t mark;
    logic  take;
    logic  drop;
    logic  advance;
    cnt_t  cnt_nxt;
    logic  rise;
    logic  fall2;
    logic  lat_wide;

    logic [DATA_W-1:0] src_word;
    logic              src_wide;
    logic [DATA_W-1:0] lane;

    assign cfg_mode = '{wide: cfg_wide, div1: cfg_div1};
    assign mark     = '{sol: in_sol, sof: in_sof};
    assign lat_wide = mode_q.wide;

    zvo_pacer u_pace (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .cfg_mode (cfg_mode),
        .take     (take),
        .drop     (drop),
        .advance  (advance),
        .cnt_nxt  (cnt_nxt),
        .mode_q   (mode_q)
    );

    assign in_ready = take;

    // edges inside a word, relative to the cycle index that comes next
    assign rise  = advance &&
                   ((cnt_nxt == half_cyc(mode_q)) ||
                    (!mode_q.wide &&
                     cnt_nxt == cnt_t'(half_cyc(mode_q) + per_cyc(mode_q))));
    assign fall2 = advance && !mode_q.wide && (cnt_nxt == per_cyc(mode_q));

    zvo_pclk_gen u_pclk (
        .clk   (clk),
        .rst   (rst),
        .inv   (cfg_invert),
        .start (take),
        .rise  (rise),
        .fall2 (fall2),
        .pclk  (vid_clk)
    );

    zvo_sync_track u_sync (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .mark    (mark),
        .drop    (drop),
        .hsync_n (vid_hsync_n),
        .vsync   (vid_vsync)
    );

    logic [DATA_W-1:0] word_q;

    assign src_word = take ? in_data : word_q;
    assign src_wide = take ? cfg_wide : mode_q.wide;

    zvo_lane_sel #(.DATA_W(DATA_W)) u_lane (
        .word (src_word),
        .wide (src_wide),
        .hi   (!take && fall2),
        .lane (lane)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            vid_data <= '0;
            vid_de   <= 1'b0;
        end else begin
            if (take) begin
                word_q <= in_data;
                vid_de <= 1'b1;
            end else if (drop) begin
                vid_de <= 1'b0;
            end
            if (take || fall2)
                vid_data <= lane;
        end
    end

endmodule

// File: rtl/zvo_port_chk.sv
module zvo_port_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_invert,
    input logic              in_valid,
    input logic              in_ready,
    input logic              vid_clk,
    input logic [DATA_W-1:0] vid_data,
    input logic              vid_hsync_n,
    input logic              vid_vsync,
    input logic              vid_de,
    input logic              lat_wide
);

    // R2
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> in_valid);

    // R3
    ready_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // R4
    take_shows_de_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> vid_de);

    // R4
    sync_on_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(vid_hsync_n) && vid_de && $stable(cfg_invert)) |-> (vid_clk == cfg_invert));

    // R10
    clk_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(vid_clk) && $stable(cfg_invert)) |-> vid_de);

    // R8
    hsync_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vid_de |-> vid_hsync_n);

    // R9
    vsync_moves_with_de_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(vid_vsync) |-> vid_de);

    // R6
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (vid_de && !lat_wide) |-> (vid_data[DATA_W-1:DATA_W/2] == '0));

endmodule

bind zvo_port zvo_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_invert  (cfg_invert),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .vid_clk     (vid_clk),
    .vid_data    (vid_data),
    .vid_hsync_n (vid_hsync_n),
    .vid_vsync   (vid_vsync),
    .vid_de      (vid_de),
    .lat_wide    (lat_wide)
);

// File: tb/tb_zvo_port.sv
module tb_zvo_port;

    localparam int CLK_PER  = 10;
    localparam int DW       = 16;
    localparam int WD_LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wide = 1'b0;
    logic          cfg_div1 = 1'b0;
    logic          cfg_invert = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic          in_sof = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          vid_clk;
    logic [DW-1:0] vid_data;
    logic          vid_hsync_n;
    logic          vid_vsync;
    logic          vid_de;

    zvo_port #(.DATA_W(DW)) dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wide    (cfg_wide),
        .cfg_div1    (cfg_div1),
        .cfg_invert  (cfg_invert),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .in_sol      (in_sol),
        .in_sof      (in_sof),
        .vid_clk     (vid_clk),
        .vid_data    (vid_data),
        .vid_hsync_n (vid_hsync_n),
        .vid_vsync   (vid_vsync),
        .vid_de      (vid_de)
    );

    always #(CLK_PER/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    int exp_d [0:255];
    bit exp_h [0:255];
    bit exp_v [0:255];
    int q_wr = 0;
    int q_rd = 0;
    bit vs_model = 0;
    bit mon_en = 0;
    bit a_prev = 1;
    bit have_prev = 0;
    int last_t = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            summary();
        end
    end

    function automatic int wlen();
        if (!cfg_wide) return 8;
        return cfg_div1 ? 2 : 4;
    endfunction

    // active edge: vid_clk reaching the level opposite to cfg_invert (R5, R11)
    always @(negedge clk) begin
        bit a;
        if (rst || !mon_en) begin
            a_prev = 1;
        end else begin
            a = (vid_clk != cfg_invert);
            if (a && !a_prev) begin
                if (q_rd == q_wr) begin
                    chk(0, "R5", "active edge with no lane pending", 1, 0);
                end else begin
                    chk(vid_de == 1'b1, "R5", "de at active edge", int'(vid_de), 1);
                    chk(int'(vid_data) == exp_d[q_rd], cfg_wide ? "R7" : "R6",
                        "data at active edge", int'(vid_data), exp_d[q_rd]);
                    chk(vid_hsync_n == exp_h[q_rd], "R8", "hsync_n at active edge",
                        int'(vid_hsync_n), int'(exp_h[q_rd]));
                    chk(vid_vsync == exp_v[q_rd], "R9", "vsync at active edge",
                        int'(vid_vsync), int'(exp_v[q_rd]));
                    q_rd++;
                end
            end
            a_prev = a;
        end
    end

    task automatic idle_checks(input string tag);
        chk(vid_de == 1'b0, "R10", {tag, " de idle"}, int'(vid_de), 0);
        chk(vid_clk == !cfg_invert, "R11", {tag, " clk idle level"},
            int'(vid_clk), int'(!cfg_invert));
        chk(vid_hsync_n == 1'b1, "R10", {tag, " hsync_n idle"}, int'(vid_hsync_n), 1);
        chk(vid_vsync == vs_model, "R9", {tag, " vsync held"},
            int'(vid_vsync), int'(vs_model));
    endtask

    task automatic apply_reset(input bit w, input bit d1, input bit inv);
        @(negedge clk);
        rst = 1'b1;
        mon_en = 0;
        in_valid = 1'b0;
        cfg_wide = w;
        cfg_div1 = d1;
        cfg_invert = inv;
        q_wr = 0;
        q_rd = 0;
        vs_model = 0;
        have_prev = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(vid_de == 1'b0, "R1", "reset de", int'(vid_de), 0);
        chk(vid_clk == !inv, "R1", "reset clk idle", int'(vid_clk), int'(!inv));
        chk(vid_hsync_n == 1'b1, "R1", "reset hsync_n", int'(vid_hsync_n), 1);
        chk(vid_vsync == 1'b0, "R1", "reset vsync", int'(vid_vsync), 0);
        chk(in_ready == 1'b0, "R1", "reset ready", int'(in_ready), 0);
        mon_en = 1;
    endtask

    task automatic send_word(input logic [DW-1:0] d, input bit sol, input bit sof,
                             input int gap);
        int t = 0;
        bit got = 0;
        int lw = wlen();
        logic [DW-1:0] first;
        if (gap > 0) begin
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        if (gap > lw) idle_checks("gap");
        in_valid = 1'b1;
        in_data = d;
        in_sol = sol;
        in_sof = sof;
        while (!got) begin
            #(CLK_PER/4);
            if (in_ready) begin
                got = 1;
                t = cyc;
            end
            @(negedge clk);
        end
        // R3
        if (have_prev && gap == 0)
            chk(t - last_t == lw, "R3", "consume spacing", t - last_t, lw);
        have_prev = 1;
        last_t = t;
        if (sof) vs_model = 1;
        else if (sol) vs_model = 0;
        first = cfg_wide ? d : {8'h00, d[7:0]};
        exp_d[q_wr] = int'(first);
        exp_h[q_wr] = !sol;
        exp_v[q_wr] = vs_model;
        q_wr++;
        if (!cfg_wide) begin
            exp_d[q_wr] = int'({8'h00, d[15:8]});
            exp_h[q_wr] = !sol;
            exp_v[q_wr] = vs_model;
            q_wr++;
        end
        // R4: everything lands on the consuming edge
        chk(vid_de == 1'b1, "R4", "de after consume", int'(vid_de), 1);
        chk(vid_clk == cfg_invert, "R4", "clk inactive after consume",
            int'(vid_clk), int'(cfg_invert));
        chk(vid_data == first, "R4", "first lane after consume",
            int'(vid_data), int'(first));
        chk(vid_hsync_n == !sol, "R4", "hsync_n after consume",
            int'(vid_hsync_n), int'(!sol));
        chk(vid_vsync == vs_model, "R4", "vsync after consume",
            int'(vid_vsync), int'(vs_model));
        in_valid = 1'b0;
    endtask

    task automatic run_cfg(input bit w, input bit d1, input bit inv);
        int code = {29'd0, w, d1, inv};
        apply_reset(w, d1, inv);
        for (int i = 0; i < 24; i++) begin
            int gap;
            logic [DW-1:0] d;
            gap = (i == 2) ? 12 : (i == 6) ? 2 : (i == 13) ? 10 : (i == 18) ? 1 : 0;
            d = DW'((i * 4099 + code * 771 + 16'h3C5A) & 16'hFFFF);
            send_word(d, (i % 4) == 0, (i % 12) == 0, gap);
        end
        repeat (12) @(negedge clk);
        // R5: each lane got its active edge
        chk(q_rd == q_wr, "R5", "lanes left without an edge", q_wr - q_rd, 0);
        idle_checks("end");
    endtask

    initial begin
        for (int w = 0; w < 2; w++)
            for (int d1 = 0; d1 < 2; d1++)
                for (int inv = 0; inv < 2; inv++)
                    run_cfg(w[0], d1[0], inv[0]);
        done = 1;
        summary();
    end

endmodule